// File: doc/BRIEF.md
# Interrupt Mapping and Dispatch Controller

This block gathers 64 level-sensitive interrupt lines and presents them to a processor one at a time as a single numbered request. Lines 0 to 31 come from PCI slots, and each group of four consecutive PCI lines shares one map register. Lines 32 to 63 come from on-board devices, and each of these lines has a map register of its own. The enable flag in bit 31 of a map register decides whether its lines may be dispatched.

When no request is outstanding, the controller chooses the lowest-numbered pending line whose map entry is enabled. Because PCI lines have lower numbers, every PCI line wins over every on-board line. The chosen request is held until software writes the matching clear register, or until software writes a 0 enable into the map register that covers it. The request is dropped on the cycle after that write, and arbitration runs again on the cycle after the drop.

Software reaches the registers through a 32-bit word bus with a 16-bit byte address. Each register occupies an 8-byte slot, or a 32-byte slot for the PCI clear registers. Only the upper word of a slot (address bit 2 = 1, bits 1:0 = 0) is live. The lower word reads as zero and ignores writes.

Top module: `irq_dispatch`

## Requirements
- R1: Asynchronous reset clears every enable bit, every pending bit and the outstanding request. After reset, PCI map register g reads 0x7C0 | (g<<2), and on-board map register i reads 0x7E0 | i.
- R2: PCI map register g is at 0x0C04 + 8g, and on-board map register i is at 0x1004 + 8i. A write changes only bit 31, the enable, and bits 30:0 always read their fixed value. The lower word of any slot (address bit 2 = 0) reads 0 and ignores writes.
- R3: PCI line n is enabled by the bit 31 of PCI map register n/4. A pending line whose entry is disabled is never dispatched.
- R4: A line that is high before clock edge k is latched as pending at edge k. If it wins arbitration, its request is visible after edge k+1.
- R5: With no request outstanding, arbitration selects the lowest-numbered pending enabled line, so any PCI line (0 to 31) wins over any on-board line (32 to 63).
- R6: While a request is outstanding, its index does not change. This holds when new lines rise, when map entries are enabled, and when the outstanding line itself deasserts.
- R7: PCI clear registers are at 0x1404 + 32s. A write whose slot s equals the outstanding index / 4 (the index being below 32) drops the request after the next edge. A write to any other slot has no effect.
- R8: On-board clear register i is at 0x1804 + 8i. A write drops an outstanding request only if that request's index is 32 + i.
- R9: A map write with bit 31 = 0 to the entry that covers the outstanding request drops it after the next edge. Arbitration resumes one edge later.
- R10: req_o is all zero when req_vld_o is low. Otherwise it is one-hot, with its single set bit at req_idx_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 64 | Level interrupt lines; 0-31 PCI, 32-63 on-board |
| bus_vld_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 16 | Byte address within the register window |
| bus_wdata_i | input | 32 | Write data; only bit 31 is stored |
| rdata_o | output | 32 | Combinational read data for the current address |
| req_o | output | 64 | One-hot outstanding request vector |
| req_vld_o | output | 1 | A request is outstanding |
| req_idx_o | output | 6 | Index of the outstanding request |

## Verification
An input that changes before edge k can first appear on req_o after edge k+1, because the pending latch and the request register each add one edge. A clear write or a disabling map write removes the request after the next edge, and a replacement request appears one edge after that. Reads are combinational and are compared a short delay after the address is applied. Each expected request is queued together with the cycle it is due, and the monitor compares it at the falling edge of that exact cycle. Checks that expect no change are placed on both cycles where a wrong drop or a wrong re-arbitration would show.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int unsigned NUM_PCI     = 32;
  localparam int unsigned NUM_OBIO    = 32;
  localparam int unsigned PCI_PER_GRP = 4;
  localparam int unsigned NUM_GRP     = NUM_PCI / PCI_PER_GRP;
  localparam int unsigned NUM_LINES   = NUM_PCI + NUM_OBIO;
  localparam int unsigned IDX_W       = $clog2(NUM_LINES);
  localparam int unsigned GRP_W       = $clog2(NUM_GRP);
  localparam int unsigned OB_W        = $clog2(NUM_OBIO);
  localparam int unsigned ENT_W       = (OB_W > GRP_W) ? OB_W : GRP_W;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 32;

  localparam logic [ADDR_W-1:0] PCI_MAP_BASE  = 16'h0C00;
  localparam logic [ADDR_W-1:0] OBIO_MAP_BASE = 16'h1000;
  localparam logic [ADDR_W-1:0] PCI_CLR_BASE  = 16'h1400;
  localparam logic [ADDR_W-1:0] OBIO_CLR_BASE = 16'h1800;

  // fixed low bits of the map registers
  localparam logic [DATA_W-2:0] MAP_FIXED = 31'h7C0;
  localparam logic [DATA_W-2:0] OBIO_TAG  = 31'h020;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PCI_MAP,
    REG_OBIO_MAP,
    REG_PCI_CLR,
    REG_OBIO_CLR
  } reg_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_dispatch_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [ENT_W-1:0]  ent_o,
  output logic              live_o
);
  localparam int unsigned PMAP_LSB = $clog2(NUM_GRP * 8);
  localparam int unsigned OMAP_LSB = $clog2(NUM_OBIO * 8);
  localparam int unsigned PCLR_LSB = $clog2(NUM_GRP * 32);
  localparam int unsigned OCLR_LSB = $clog2(NUM_OBIO * 8);

  always_comb begin
    kind_o = REG_NONE;
    ent_o  = '0;
    if (addr_i[ADDR_W-1:PMAP_LSB] == PCI_MAP_BASE[ADDR_W-1:PMAP_LSB]) begin
      kind_o = REG_PCI_MAP;
      ent_o  = ENT_W'(addr_i[3 +: GRP_W]);
    end else if (addr_i[ADDR_W-1:OMAP_LSB] == OBIO_MAP_BASE[ADDR_W-1:OMAP_LSB]) begin
      kind_o = REG_OBIO_MAP;
      ent_o  = ENT_W'(addr_i[3 +: OB_W]);
    end else if (addr_i[ADDR_W-1:PCLR_LSB] == PCI_CLR_BASE[ADDR_W-1:PCLR_LSB]) begin
      kind_o = REG_PCI_CLR;
      ent_o  = ENT_W'(addr_i[5 +: GRP_W]);
    end else if (addr_i[ADDR_W-1:OCLR_LSB] == OBIO_CLR_BASE[ADDR_W-1:OCLR_LSB]) begin
      kind_o = REG_OBIO_CLR;
      ent_o  = ENT_W'(addr_i[3 +: OB_W]);
    end
  end

  // upper word of each slot, word aligned
  assign live_o = addr_i[2] & (addr_i[1:0] == 2'b00);
endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_dispatch_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  reg_kind_e          kind_i,
  input  logic [ENT_W-1:0]   ent_i,
  input  logic               live_i,
  input  logic               wen_i,
  input  logic               out_vld_i,
  input  logic [IDX_W-1:0]   out_idx_i,
  output logic [NUM_GRP-1:0]  grp_en_o,
  output logic [NUM_OBIO-1:0] obio_en_o,
  output logic               drop_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic              wr_act;
  logic              out_obio, out_pci;
  logic [OB_W-1:0]   out_low;
  logic [GRP_W-1:0]  out_grp;
  logic [GRP_W-1:0]  ent_grp;

  assign wr_act   = wr_i & live_i;
  assign out_obio = out_vld_i & out_idx_i[IDX_W-1];
  assign out_pci  = out_vld_i & ~out_idx_i[IDX_W-1];
  assign out_low  = out_idx_i[OB_W-1:0];
  assign out_grp  = out_low[OB_W-1 -: GRP_W];
  assign ent_grp  = ent_i[GRP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_en_o  <= '0;
      obio_en_o <= '0;
    end else if (wr_act) begin
      if (kind_i == REG_PCI_MAP)  grp_en_o[ent_grp]          <= wen_i;
      if (kind_i == REG_OBIO_MAP) obio_en_o[ent_i[OB_W-1:0]] <= wen_i;
    end
  end

  always_comb begin
    drop_o = 1'b0;
    if (wr_act) begin
      unique case (kind_i)
        REG_PCI_CLR:  drop_o = out_pci  && (out_grp == ent_grp);
        REG_OBIO_CLR: drop_o = out_obio && (out_low == ent_i[OB_W-1:0]);
        REG_PCI_MAP:  drop_o = !wen_i && out_pci  && (out_grp == ent_grp);
        REG_OBIO_MAP: drop_o = !wen_i && out_obio && (out_low == ent_i[OB_W-1:0]);
        default:      drop_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (live_i) begin
      if (kind_i == REG_PCI_MAP)
        rdata_o = {grp_en_o[ent_grp], MAP_FIXED | ((DATA_W-1)'(ent_grp) << 2)};
      else if (kind_i == REG_OBIO_MAP)
        rdata_o = {obio_en_o[ent_i[OB_W-1:0]],
                   MAP_FIXED | OBIO_TAG | (DATA_W-1)'(ent_i[OB_W-1:0])};
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 64,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] cand_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |cand_i;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 bus_vld_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_LINES-1:0] req_o,
  output logic                 req_vld_o,
  output logic [IDX_W-1:0]     req_idx_o
);
  reg_kind_e            kind;
  logic [ENT_W-1:0]     ent;
  logic                 live;
  logic [NUM_GRP-1:0]   grp_en;
  logic [NUM_OBIO-1:0]  obio_en;
  logic                 drop;
  logic [NUM_LINES-1:0] pend_q, line_en;
  logic                 cand_any;
  logic [IDX_W-1:0]     cand_idx;
  logic                 out_vld_q;
  logic [IDX_W-1:0]     out_idx_q;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-2:0];

  irq_reg_decode u_dec (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .ent_o  (ent),
    .live_o (live)
  );

  irq_map_regs u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_vld_i & bus_we_i),
    .kind_i    (kind),
    .ent_i     (ent),
    .live_i    (live),
    .wen_i     (bus_wdata_i[DATA_W-1]),
    .out_vld_i (out_vld_q),
    .out_idx_i (out_idx_q),
    .grp_en_o  (grp_en),
    .obio_en_o (obio_en),
    .drop_o    (drop),
    .rdata_o   (rdata_o)
  );

  for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci_en
    assign line_en[p] = grp_en[p / PCI_PER_GRP];
  end
  for (genvar o = 0; o < NUM_OBIO; o++) begin : g_obio_en
    assign line_en[NUM_PCI + o] = obio_en[o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= irq_i;
  end

  irq_prio_pick #(.N(NUM_LINES), .W(IDX_W)) u_pick (
    .cand_i (pend_q & line_en),
    .any_o  (cand_any),
    .idx_o  (cand_idx)
  );

  // drop has a cycle of its own; a fresh pick follows on the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_idx_q <= '0;
    end else if (drop) begin
      out_vld_q <= 1'b0;
    end else if (!out_vld_q && cand_any) begin
      out_vld_q <= 1'b1;
      out_idx_q <= cand_idx;
    end
  end

  for (genvar r = 0; r < NUM_LINES; r++) begin : g_req
    assign req_o[r] = out_vld_q && (out_idx_q == IDX_W'(r));
  end

  assign req_vld_o = out_vld_q;
  assign req_idx_o = out_idx_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_i,
  input logic                 bus_vld_i,
  input logic                 bus_we_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_LINES-1:0] req_o,
  input logic                 req_vld_o,
  input logic [IDX_W-1:0]     req_idx_o
);
  // R10
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o) && ((req_o != '0) == req_vld_o));

  // R10
  req_idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o |-> req_o[req_idx_o]);

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_o && $past(req_vld_o)) |-> (req_idx_o == $past(req_idx_o)));

  // R4
  req_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_vld_o) |-> (($past(irq_i, 2) & req_o) != '0));

  // R2
  low_word_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_vld_i && !bus_we_i && !bus_addr_i[2]) |-> (rdata_o == '0));

  // R7
  pci_clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_vld_i && bus_we_i && bus_addr_i[2] && (bus_addr_i[1:0] == 2'b00) &&
     (bus_addr_i[15:8] == PCI_CLR_BASE[15:8]) && req_vld_o &&
     !req_idx_o[IDX_W-1] && (req_idx_o[4:2] == bus_addr_i[7:5]))
    |=> !req_vld_o);
endmodule

bind irq_dispatch irq_dispatch_chk u_chk (.*);

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_i = '0;
  logic        bus_vld_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] req_o;
  logic        req_vld_o;
  logic [5:0]  req_idx_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {
    int    due;
    bit    vld;
    int    idx;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  irq_dispatch uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .bus_vld_i   (bus_vld_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .rdata_o     (rdata_o),
    .req_o       (req_o),
    .req_vld_o   (req_vld_o),
    .req_idx_o   (req_idx_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_at(input int d, input bit v, input int idx, input string tag);
    sb_q.push_back('{due: cyc + d, vld: v, idx: idx, tag: tag});
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_vld_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_vld_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] e, input string tag);
    bus_vld_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1;
    checks++;
    if (rdata_o !== e) begin
      fails++;
      $display("FAIL %s read 0x%h: got 0x%h expected 0x%h", tag, a, rdata_o, e);
    end
    bus_vld_i = 1'b0;
  endtask

  // monitor: compare queued expectations in their due cycle
  initial begin
    forever begin
      @(negedge clk_i);
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        exp_t e;
        logic [63:0] ev;
        e = sb_q.pop_front();
        ev = e.vld ? (64'd1 << e.idx) : 64'd0;
        checks++;
        if (e.due != cyc || req_vld_o !== e.vld || req_o !== ev ||
            (e.vld && req_idx_o !== 6'(e.idx))) begin
          fails++;
          $display("FAIL %s cyc %0d: got vld=%0b idx=%0d req=%h expected vld=%0b idx=%0d req=%h",
                   e.tag, cyc, req_vld_o, req_idx_o, req_o, e.vld, e.idx, ev);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got no end, expected finish");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    // R1 reset values
    rd_chk(16'h0C04, 32'h0000_07C0, "R1");
    rd_chk(16'h0C3C, 32'h0000_07DC, "R1");
    rd_chk(16'h1004, 32'h0000_07E0, "R1");
    rd_chk(16'h10FC, 32'h0000_07FF, "R1");
    expect_at(1, 0, 0, "R1");
    tick(2);
    // R2 write mask and low word
    rd_chk(16'h0C00, 32'h0, "R2");
    wr(16'h0C00, 32'h8000_0000);
    rd_chk(16'h0C04, 32'h0000_07C0, "R2");
    wr(16'h0C04, 32'hFFFF_FFFF);
    rd_chk(16'h0C04, 32'h8000_07C0, "R2");
    rd_chk(16'h0C00, 32'h0, "R2");
    // R4 latency
    irq_i[2] = 1'b1;
    expect_at(1, 0, 0, "R4");
    expect_at(2, 1, 2, "R4");
    tick(3);
    // R6 hold against new lines and own deassertion
    irq_i[0] = 1'b1; irq_i[1] = 1'b1;
    expect_at(3, 1, 2, "R6");
    tick(3);
    irq_i[2] = 1'b0;
    expect_at(3, 1, 2, "R6");
    tick(4);
    // R7 wrong slot, then matching slot
    expect_at(1, 1, 2, "R7");
    expect_at(2, 1, 2, "R7");
    wr(16'h1424, 32'h0);
    tick(2);
    expect_at(1, 0, 0, "R7");
    expect_at(2, 1, 0, "R5");
    wr(16'h1404, 32'h0);
    tick(2);
    // R9 disable outstanding group
    expect_at(1, 0, 0, "R9");
    expect_at(3, 0, 0, "R9");
    wr(16'h0C04, 32'h0);
    tick(3);
    // on-board lines; group 1 still disabled (R3)
    irq_i[35] = 1'b1; irq_i[37] = 1'b1; irq_i[4] = 1'b1;
    expect_at(2, 1, 35, "R3");
    wr(16'h101C, 32'h8000_0000);
    wr(16'h102C, 32'h8000_0000);
    tick(1);
    rd_chk(16'h101C, 32'h8000_07E3, "R2");
    expect_at(2, 1, 35, "R6");
    wr(16'h0C0C, 32'h8000_0000);
    tick(1);
    // R8 wrong index, then matching index
    expect_at(2, 1, 35, "R8");
    wr(16'h182C, 32'h0);
    tick(1);
    expect_at(1, 0, 0, "R8");
    expect_at(2, 1, 4, "R5");
    wr(16'h181C, 32'h0);
    tick(1);
    // R3 another line of group 1
    irq_i[4] = 1'b0; irq_i[7] = 1'b1;
    expect_at(1, 0, 0, "R7");
    expect_at(2, 1, 7, "R3");
    wr(16'h1424, 32'h0);
    tick(1);
    irq_i[7] = 1'b0;
    expect_at(1, 0, 0, "R7");
    expect_at(2, 1, 35, "R5");
    wr(16'h1424, 32'h0);
    tick(1);
    // R9 on-board disable, next on-board line follows
    expect_at(1, 0, 0, "R9");
    expect_at(2, 1, 37, "R9");
    wr(16'h101C, 32'h0);
    tick(1);
    irq_i[37] = 1'b0;
    expect_at(3, 1, 37, "R6");
    tick(4);
    // R1 reset during activity
    rst_ni = 1'b0;
    #1;
    checks++;
    if (req_vld_o !== 1'b0 || req_o !== 64'd0) begin
      fails++;
      $display("FAIL R1 reset: got vld=%0b req=%h expected vld=0 req=0", req_vld_o, req_o);
    end
    tick(1);
    rst_ni = 1'b1;
    rd_chk(16'h0C0C, 32'h0000_07C4, "R1");
    rd_chk(16'h102C, 32'h0000_07E5, "R1");
    expect_at(3, 0, 0, "R1");
    tick(4);
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule